// File: doc/BRIEF.md
# Halfword Instruction Prefetch Aligner

This block sits between a 32-bit instruction fetch port and the decode stage of a three-stage fetch, decode and execute pipeline. Every fetch returns one word aligned to a word address. The word can hold two 16-bit instructions, one 32-bit instruction, or part of an instruction that crosses into the next word. A short halfword queue merges the leftover upper half of one fetch word with the lower half of the next. Decode therefore receives one complete instruction per cycle, and an unaligned 32-bit instruction causes no bubble.

The block drives the word address it wants next and accepts a word whenever the fetch side marks it valid and the queue has room. Halfwords are taken in program order. The block classifies the halfword at the head of the queue and loads the output register with a 16-bit or a 32-bit instruction, its address, and its PC-read value. A redirect empties the queue and the output register and restarts fetch at the word that holds the target address.

Top module: `hw_prefetch_align`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0, `fetch_ready` is 1, and `fetch_addr` equals `reset_addr` with bits [1:0] cleared. The first instruction issued has address `reset_addr` with bit 0 cleared. If bit 1 of that address is set, the lower halfword of the first word is dropped.
- R2: A halfword whose bits [15:11] are 5'b11101, 5'b11110 or 5'b11111 starts a 32-bit instruction and sets `out_is32` to 1. Any other halfword is a complete 16-bit instruction and sets `out_is32` to 0.
- R3: Bits [15:0] of a fetch word precede bits [31:16] in program order. A 32-bit instruction is issued with its first halfword in `out_instr[15:0]` and its second halfword in `out_instr[31:16]`. A 16-bit instruction appears in `out_instr[15:0]`, and `out_instr[31:16]` is zero.
- R4: While `fetch_valid` and `dec_ready` both stay at 1, `out_valid` is 1 on every cycle from the third cycle after a redirect or after reset onward. This includes 32-bit instructions that start on an upper halfword.
- R5: `out_pc` equals `out_addr + 4`. Each accepted instruction is followed by the next one at `out_addr + 2` for a 16-bit instruction or `out_addr + 4` for a 32-bit instruction.
- R6: A redirect clears `out_valid` on the next cycle and empties the queue. On that next cycle `fetch_addr` is the target with bits [1:0] cleared. The next instruction issued has the target address, and a target on an upper halfword drops the lower halfword. A fetch word presented in the redirect cycle is dropped. Any decode handshake in that cycle is void.
- R7: While `out_valid` is 1 and `dec_ready` is 0, the output holds unchanged. The queue stores at most three halfwords (one word plus one halfword), and `fetch_ready` is 1 only while it holds at most one halfword.
- R8: Cycles with `fetch_valid` at 0, or with `dec_ready` at 0, delay the instruction stream but never drop, repeat or reorder any instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_addr | input | AW | Start address used at reset (halfword aligned) |
| fetch_addr | output | AW | Word address of the next fetch word wanted |
| fetch_ready | output | 1 | Queue can accept a fetch word this cycle |
| fetch_valid | input | 1 | `fetch_data` holds the word at `fetch_addr` |
| fetch_data | input | 32 | Fetched word, lower halfword first |
| redirect | input | 1 | Branch redirect, flushes queue and output |
| redirect_target | input | AW | Halfword address of the redirect target |
| dec_ready | input | 1 | Decode accepts the output this cycle |
| out_valid | output | 1 | Output register holds an instruction |
| out_instr | output | 32 | Instruction, zero-extended when 16-bit |
| out_is32 | output | 1 | 1 for a 32-bit instruction |
| out_addr | output | AW | Address of the issued instruction |
| out_pc | output | AW | PC-read value, address plus 4 |

## Verification
The bench builds the block with a 16-bit address and the minimum three-halfword queue. With that queue, the full-queue back-pressure point is reached within a few stalled cycles. The instruction memory is a function of the halfword index, so every 32-bit prefix and every alignment comes up within a short address range. The bench sweeps redirect targets across 32 consecutive halfword positions, which covers both word offsets with both instruction sizes at the head. It also runs fetch-gap and decode-stall patterns against a reference walk of the same memory.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef logic [HALF_W-1:0] half_t;

  // top five bits 11101, 11110, 11111 open a two-halfword instruction
  function automatic logic is_wide(input half_t h);
    return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
  endfunction
endpackage

// File: rtl/pfa_fetch_ptr.sv
module pfa_fetch_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reset_addr,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_target,
  input  logic          take,
  output logic [AW-1:0] fetch_addr,
  output logic          skip_low
);
  logic [AW-3:0] word_ptr;
  logic          skip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_ptr <= reset_addr[AW-1:2];
      skip_q   <= reset_addr[1];
    end else if (redirect) begin
      word_ptr <= redirect_target[AW-1:2];
      skip_q   <= redirect_target[1];
    end else if (take) begin
      word_ptr <= word_ptr + 1'b1;
      skip_q   <= 1'b0;
    end
  end

  assign fetch_addr = {word_ptr, 2'b00};
  assign skip_low   = skip_q;
endmodule

// File: rtl/pfa_hw_window.sv
module pfa_hw_window
  import pfa_pkg::*;
#(
  parameter int BUF_HW = 3,
  parameter int CW     = $clog2(BUF_HW + 3)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          take,
  input  logic          skip_low,
  input  logic [31:0]   word,
  input  logic [1:0]    consume,
  output logic [CW-1:0] count,
  output logic [CW-1:0] avail,
  output half_t         head0,
  output half_t         head1
);
  localparam int VW = BUF_HW + 2;
  localparam int IW = $clog2(VW);

  half_t         q     [BUF_HW];
  half_t         q_n   [BUF_HW];
  half_t         view  [VW];
  logic [CW-1:0] cnt;
  logic [CW-1:0] inc;
  half_t         in0;
  half_t         in1;

  always_comb begin
    in0 = skip_low ? word[31:16] : word[15:0];
    in1 = word[31:16];
    if (!take)         inc = '0;
    else if (skip_low) inc = CW'(1);
    else               inc = CW'(2);
  end

  // queued halfwords first, then the halfwords of the incoming word
  always_comb begin
    for (int i = 0; i < VW; i++) begin
      if (i < BUF_HW && i < int'(cnt)) view[i] = q[i];
      else if (i == int'(cnt))         view[i] = in0;
      else                             view[i] = in1;
    end
  end

  always_comb begin
    for (int j = 0; j < BUF_HW; j++) begin
      logic [IW-1:0] idx;
      idx    = IW'(j) + IW'(consume);
      q_n[j] = view[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) cnt <= '0;
    else              cnt <= cnt + inc - CW'(consume);
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < BUF_HW; j++) q[j] <= q_n[j];
  end

  assign count = cnt;
  assign avail = cnt + inc;
  assign head0 = view[0];
  assign head1 = view[1];
endmodule

// File: rtl/pfa_issue.sv
module pfa_issue
  import pfa_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [AW-1:0] reset_addr,
  input  logic [AW-1:0] redirect_target,
  input  logic          dec_ready,
  input  half_t         head0,
  input  half_t         head1,
  input  logic [CW-1:0] avail,
  output logic [1:0]    consume,
  output logic          out_valid,
  output logic [31:0]   out_instr,
  output logic          out_is32,
  output logic [AW-1:0] out_addr,
  output logic [AW-1:0] out_pc
);
  logic [AW-1:0] next_addr;
  logic          can_load;
  logic          wide;
  logic [1:0]    need;
  logic          issue;

  always_comb begin
    can_load = !out_valid || dec_ready;
    wide     = is_wide(head0);
    need     = wide ? 2'd2 : 2'd1;
    issue    = can_load && !flush && (avail >= CW'(need));
    consume  = issue ? need : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      next_addr <= {reset_addr[AW-1:1], 1'b0};
    end else if (flush) begin
      out_valid <= 1'b0;
      next_addr <= {redirect_target[AW-1:1], 1'b0};
    end else if (can_load) begin
      out_valid <= issue;
      if (issue) next_addr <= next_addr + AW'({need, 1'b0});
    end
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      out_instr <= wide ? {head1, head0} : {16'h0000, head0};
      out_is32  <= wide;
      out_addr  <= next_addr;
      out_pc    <= next_addr + AW'(4);
    end
  end
endmodule

// File: rtl/hw_prefetch_align.sv
module hw_prefetch_align #(
  parameter int AW     = 16,
  parameter int BUF_HW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reset_addr,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_ready,
  input  logic          fetch_valid,
  input  logic [31:0]   fetch_data,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_target,
  input  logic          dec_ready,
  output logic          out_valid,
  output logic [31:0]   out_instr,
  output logic          out_is32,
  output logic [AW-1:0] out_addr,
  output logic [AW-1:0] out_pc
);
  import pfa_pkg::*;

  localparam int CW = $clog2(BUF_HW + 3);

  logic          take;
  logic          skip_low;
  logic [CW-1:0] count;
  logic [CW-1:0] avail;
  logic [1:0]    consume;
  half_t         head0;
  half_t         head1;

  assign fetch_ready = (count <= CW'(BUF_HW - 2));
  assign take        = fetch_valid && fetch_ready && !redirect;

  pfa_fetch_ptr #(.AW(AW)) i_ptr (
    .clk(clk), .rst(rst), .reset_addr(reset_addr),
    .redirect(redirect), .redirect_target(redirect_target),
    .take(take), .fetch_addr(fetch_addr), .skip_low(skip_low)
  );

  pfa_hw_window #(.BUF_HW(BUF_HW), .CW(CW)) i_win (
    .clk(clk), .rst(rst), .flush(redirect), .take(take),
    .skip_low(skip_low), .word(fetch_data), .consume(consume),
    .count(count), .avail(avail), .head0(head0), .head1(head1)
  );

  pfa_issue #(.AW(AW), .CW(CW)) i_iss (
    .clk(clk), .rst(rst), .flush(redirect), .reset_addr(reset_addr),
    .redirect_target(redirect_target), .dec_ready(dec_ready),
    .head0(head0), .head1(head1), .avail(avail), .consume(consume),
    .out_valid(out_valid), .out_instr(out_instr), .out_is32(out_is32),
    .out_addr(out_addr), .out_pc(out_pc)
  );
endmodule

// File: rtl/pfa_checker.sv
module pfa_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          redirect,
  input logic          dec_ready,
  input logic          out_valid,
  input logic [31:0]   out_instr,
  input logic          out_is32,
  input logic [AW-1:0] out_addr,
  input logic [AW-1:0] out_pc
);
  logic          trk_v;
  logic [AW-1:0] trk_addr;

  always_ff @(posedge clk) begin
    if (rst || redirect) begin
      trk_v    <= 1'b0;
      trk_addr <= '0;
    end else if (out_valid && dec_ready) begin
      trk_v    <= 1'b1;
      trk_addr <= out_addr + (out_is32 ? AW'(4) : AW'(2));
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_size_flag_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_is32 == (out_instr[15:13] == 3'b111 && out_instr[12:11] != 2'b00));

  p_zero_ext_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is32 |-> out_instr[31:16] == 16'h0000);

  p_pc_offset_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_pc == out_addr + AW'(4));

  p_addr_seq_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && trk_v |-> out_addr == trk_addr);

  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !dec_ready && !redirect |=>
      out_valid && $stable(out_instr) && $stable(out_addr) && $stable(out_is32));
endmodule

bind hw_prefetch_align pfa_checker #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .redirect(redirect), .dec_ready(dec_ready),
  .out_valid(out_valid), .out_instr(out_instr), .out_is32(out_is32),
  .out_addr(out_addr), .out_pc(out_pc)
);

// File: tb/test_hw_prefetch_align.sv
`timescale 1ns/1ps
module test_hw_prefetch_align;
  localparam int AW = 16;
  localparam logic [AW-1:0] RST_ADDR = 16'h0102;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] fetch_addr;
  logic          fetch_ready;
  logic          fetch_valid = 1'b0;
  logic [31:0]   fetch_data;
  logic          redirect = 1'b0;
  logic [AW-1:0] redirect_target = '0;
  logic          dec_ready = 1'b0;
  logic          out_valid;
  logic [31:0]   out_instr;
  logic          out_is32;
  logic [AW-1:0] out_addr;
  logic [AW-1:0] out_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hw_prefetch_align #(.AW(AW), .BUF_HW(3)) i_hw_prefetch_align (
    .clk(clk), .rst(rst), .reset_addr(RST_ADDR),
    .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .redirect(redirect), .redirect_target(redirect_target),
    .dec_ready(dec_ready), .out_valid(out_valid), .out_instr(out_instr),
    .out_is32(out_is32), .out_addr(out_addr), .out_pc(out_pc)
  );

  // program memory computed from the halfword index
  function automatic logic [15:0] hw_at(input int k);
    int sel;
    logic [4:0] top;
    sel = (k * 37 + k / 8) % 6;
    case (sel)
      0: top = 5'b11101;
      1: top = 5'b11110;
      2: top = 5'b11111;
      default: top = 5'(k % 29);
    endcase
    return {top, 11'(k ^ 'h2A5)};
  endfunction

  always_comb begin
    int k0;
    k0 = int'(fetch_addr[AW-1:1]);
    fetch_data = {hw_at(k0 + 1), hw_at(k0)};
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [AW-1:0] exp_addr = RST_ADDR;
  logic [AW-1:0] last_tgt = '0;
  bit            expect_idle = 0;
  bit            held_v = 0;
  logic [31:0]   held_instr;
  logic [AW-1:0] held_addr;
  bit            steady = 0;
  int            since = 0;

  task automatic cycle(input bit fv, input bit dr, input bit rd,
                       input logic [AW-1:0] tgt);
    logic [15:0] h0;
    bit          wide;
    logic [31:0] e_instr;
    @(negedge clk);
    fetch_valid = fv; dec_ready = dr; redirect = rd; redirect_target = tgt;
    if (expect_idle) begin
      chk(out_valid == 1'b0, "R6 valid cleared", 32'(out_valid), 32'd0);
      chk(fetch_addr == {last_tgt[AW-1:2], 2'b00}, "R6 fetch at target word",
          32'(fetch_addr), 32'({last_tgt[AW-1:2], 2'b00}));
      expect_idle = 0;
    end else if (out_valid) begin
      if (held_v) begin
        chk(out_instr == held_instr && out_addr == held_addr, "R7 output held",
            out_instr, held_instr);
      end
      if (!rd) begin
        if (dr) begin
          h0      = hw_at(int'(exp_addr[AW-1:1]));
          wide    = (h0[15:11] >= 5'd29);
          e_instr = wide ? {hw_at(int'(exp_addr[AW-1:1]) + 1), h0} : {16'h0, h0};
          chk(out_addr == exp_addr, "R5/R8 address order", 32'(out_addr), 32'(exp_addr));
          chk(out_is32 == wide, "R2 size flag", 32'(out_is32), 32'(wide));
          chk(out_instr == e_instr, "R3 instruction field", out_instr, e_instr);
          chk(out_pc == exp_addr + AW'(4), "R5 pc value", 32'(out_pc),
              32'(exp_addr + AW'(4)));
          exp_addr = exp_addr + (wide ? AW'(4) : AW'(2));
          held_v = 0;
        end else begin
          held_v = 1; held_instr = out_instr; held_addr = out_addr;
        end
      end
    end
    if (steady && since >= 3)
      chk(out_valid == 1'b1, "R4 no bubble", 32'(out_valid), 32'd1);
    since++;
    if (rd) begin
      exp_addr = {tgt[AW-1:1], 1'b0};
      last_tgt = tgt;
      expect_idle = 1;
      held_v = 0;
      since = 0;
    end
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle in reset", 32'(out_valid), 32'd0);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle after reset", 32'(out_valid), 32'd0);
    chk(fetch_ready == 1'b1, "R1 ready after reset", 32'(fetch_ready), 32'd1);
    chk(fetch_addr == {RST_ADDR[AW-1:2], 2'b00}, "R1 first fetch word",
        32'(fetch_addr), 32'({RST_ADDR[AW-1:2], 2'b00}));
    since = 1;

    // R4: free run from reset, start on an upper halfword
    steady = 1;
    for (int c = 0; c < 40; c++) cycle(1, 1, 0, '0);

    // R6/R4: sweep redirect targets over 32 halfword positions
    for (int t = 0; t < 32; t++) begin
      steady = 0;
      cycle(1, 1, 1, AW'(16'h0400 + t * 2));
      steady = 1;
      for (int c = 0; c < 10; c++) cycle(1, 1, 0, '0);
    end
    steady = 0;

    // R8: fetch gaps and decode stalls
    for (int p = 0; p < 8; p++) begin
      cycle(1, 1, 1, AW'(16'h0800 + p * 6));
      for (int c = 0; c < 16; c++)
        cycle(((c + p) % 3) != 0, ((c * p + c) % 4) != 1, 0, '0);
    end

    // R7: long decode stall fills the queue
    cycle(1, 1, 1, AW'(16'h0A02));
    for (int c = 0; c < 6; c++) cycle(1, 0, 0, '0);
    chk(fetch_ready == 1'b0, "R7 fetch back-pressure", 32'(fetch_ready), 32'd0);
    for (int c = 0; c < 12; c++) cycle(1, 1, 0, '0);

    // R6: redirect while stalled, then drain
    for (int c = 0; c < 4; c++) cycle(1, 0, 0, '0);
    cycle(1, 0, 1, AW'(16'h0C06));
    for (int c = 0; c < 12; c++) cycle(1, 1, 0, '0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule